// File: doc/BRIEF.md
# Long-Mode Interrupt Entry Sequencer

This block delivers an interrupt or trap to a 64-bit handler. Given a vector number and the return instruction pointer, it reads the 16-byte gate entry from the interrupt table through a one-request-at-a-time 64-bit memory port. It validates the gate, then reads the target code-segment descriptor from either the local or the global descriptor table. Once every check has passed, it pushes a five-quadword return frame onto a 16-byte-aligned stack and presents the new code selector, instruction pointer, stack pointer and flags word.

All validation happens before the first stack write. A failed check ends the run with a single fault pulse (error code zero). In that case no memory write is issued and the register outputs keep their previous values. Two cases need a stack switch: a nonzero stack-table index, or a code-segment privilege that differs from the current level. This block does not handle a stack switch, so it ends such a run with a separate unsupported pulse, again with no side effect. The descriptor permission checks themselves are computed outside the block and arrive as two pass/fail inputs.

Top module: `ige_entry_seq`

## Requirements
- R1: After `start` in idle, the block reads the gate's upper quadword at `idt_base + vector*16 + 8` first, then the lower quadword at `idt_base + vector*16`. Each request is held valid with a stable address until `mem_req_ready`, and the next step waits for `mem_rsp_valid`.
- R2: The gate type is lower-quadword bits 43:40. If type AND 0xE is not 0xE, the run ends in a fault with `fault_code` 0. The code-segment descriptor is then never read.
- R3: The target selector is lower-quadword bits 31:16. The third read is at `ldt_base + (selector AND 0xF8)` when selector bit 2 is 1, and at `gdt_base + (selector AND 0xF8)` when it is 0.
- R4: The target offset is {upper[31:0], lower[63:48], lower[15:0]}. If its bits 63:47 are neither all zeros nor all ones, the run ends in a fault.
- R5: `gate_chk_ok` low at the gate check, or `cs_chk_ok` low at the code-segment check, ends the run in a fault.
- R6: If all checks pass but the stack-table index (lower bits 34:32) is nonzero, or the code-segment descriptor privilege (bits 46:45) differs from `cur_cpl`, the run ends with an `unsup` pulse.
- R7: The new stack pointer is (`cur_rsp` - 40) with bits 3:0 cleared.
- R8: On success, five quadword writes go to the new stack pointer plus 0, 8, 16, 24 and 32, in that order. They carry the return RIP, the zero-extended old CS, the old RFLAGS, the old RSP and the zero-extended old SS.
- R9: With `done`, `new_rsp` is the new stack pointer, `new_cs` is the gate selector and `new_rip` is the target offset.
- R10: `new_rflags` equals the old RFLAGS with bits 8, 14 and 16 cleared, and bit 9 set to the gate type's bit 0 (lower bit 40).
- R11: A fault takes priority over an unsupported stack switch. After a fault or unsupported end, no memory write has been issued and `new_*` are unchanged.
- R12: `busy` is high from the cycle after an accepted `start` until the cycle with exactly one of `done`, `fault` or `unsup`; each lasts one cycle. `start` while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin delivery (accepted only when idle) |
| vector | input | VEC_W | Interrupt vector number |
| cur_rip | input | 64 | Return instruction pointer |
| cur_rsp | input | 64 | Current stack pointer |
| cur_rflags | input | 64 | Current flags word |
| cur_cs | input | 16 | Current code selector |
| cur_ss | input | 16 | Current stack selector |
| cur_cpl | input | 2 | Current privilege level |
| idt_base | input | 64 | Interrupt table base address |
| gdt_base | input | 64 | Global descriptor table base |
| ldt_base | input | 64 | Local descriptor table base |
| gate_chk_ok | input | 1 | External gate permission result |
| cs_chk_ok | input | 1 | External code-segment permission result |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 64 | Request byte address |
| mem_req_wdata | output | 64 | Write data |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Read data |
| busy | output | 1 | Delivery in progress |
| done | output | 1 | One-cycle success pulse |
| fault | output | 1 | One-cycle protection fault pulse |
| fault_code | output | 16 | Error code presented with the fault (zero) |
| unsup | output | 1 | One-cycle stack-switch-required pulse |
| new_cs | output | 16 | New code selector |
| new_rip | output | 64 | New instruction pointer |
| new_rsp | output | 64 | New stack pointer |
| new_rflags | output | 64 | New flags word |

## Verification
At the code-segment check, the fault decision and the stack-switch decision are made in the same cycle. The bench provokes this with a non-canonical offset paired with a nonzero stack-table index, and with a failed code-segment permission paired with a privilege mismatch. It then expects a fault pulse, no unsupported pulse, no writes and unchanged register outputs. The sweeps over all 16 gate types, all stack-table indices, all descriptor privileges and sixteen stack pointer low-nibble values compute every address, frame word and flag value arithmetically.

// File: rtl/ige_pkg.sv
package ige_pkg;
  localparam int QW   = 64;
  localparam int SELW = 16;

  typedef enum logic [3:0] {
    S_IDLE, S_GHI_REQ, S_GHI_WAIT, S_GLO_REQ, S_GLO_WAIT, S_GATE_CHK,
    S_CSD_REQ, S_CSD_WAIT, S_CS_CHK, S_PUSH, S_COMMIT
  } seq_state_t;

  typedef struct packed {
    logic            type_ok;
    logic [SELW-1:0] sel;
    logic            use_local;
    logic [7:0]      tbl_off;
    logic [QW-1:0]   target;
    logic            canon;
    logic [2:0]      ist;
    logic            if_bit;
  } gate_info_t;
endpackage

// File: rtl/ige_gate_decode.sv
module ige_gate_decode
  import ige_pkg::*;
#(
  parameter int CANON_BIT = 47
) (
  input  logic [15:0]     off_mid,
  input  logic [15:0]     off_low,
  input  logic [31:0]     off_high,
  input  logic [3:0]      gtype,
  input  logic [2:0]      ist,
  input  logic [SELW-1:0] sel,
  output gate_info_t      info
);
  localparam int TOP_BITS = QW - CANON_BIT;

  logic [QW-1:0] tgt;
  assign tgt = {off_high, off_mid, off_low};

  always_comb begin
    info.type_ok   = (gtype[3:1] == 3'b111);
    info.sel       = sel;
    info.use_local = sel[2];
    info.tbl_off   = {sel[7:3], 3'b000};
    info.target    = tgt;
    info.canon     = (tgt[QW-1:CANON_BIT] == '0) ||
                     (tgt[QW-1:CANON_BIT] == {TOP_BITS{1'b1}});
    info.ist       = ist;
    info.if_bit    = gtype[0];
  end
endmodule

// File: rtl/ige_frame_gen.sv
module ige_frame_gen
  import ige_pkg::*;
#(
  parameter int FRAME_QW   = 5,
  parameter int ALIGN_LOG2 = 4,
  localparam int SLOT_W    = $clog2(FRAME_QW)
) (
  input  logic [SLOT_W-1:0] slot,
  input  logic [QW-1:0]     ret_rip,
  input  logic [QW-1:0]     old_rsp,
  input  logic [QW-1:0]     old_rflags,
  input  logic [SELW-1:0]   old_cs,
  input  logic [SELW-1:0]   old_ss,
  output logic [QW-1:0]     base_sp,
  output logic [QW-1:0]     slot_addr,
  output logic [QW-1:0]     slot_data
);
  localparam logic [QW-1:0] FRAME_BYTES = QW'(FRAME_QW * 8);
  localparam logic [QW-1:0] ALIGN_MASK  = ~((QW'(1) << ALIGN_LOG2) - QW'(1));

  assign base_sp   = (old_rsp - FRAME_BYTES) & ALIGN_MASK;
  assign slot_addr = base_sp + {{(QW-SLOT_W-3){1'b0}}, slot, 3'b000};

  always_comb begin
    case (slot)
      SLOT_W'(0): slot_data = ret_rip;
      SLOT_W'(1): slot_data = {{(QW-SELW){1'b0}}, old_cs};
      SLOT_W'(2): slot_data = old_rflags;
      SLOT_W'(3): slot_data = old_rsp;
      SLOT_W'(4): slot_data = {{(QW-SELW){1'b0}}, old_ss};
      default:    slot_data = '0;
    endcase
  end
endmodule

// File: rtl/ige_entry_seq.sv
module ige_entry_seq
  import ige_pkg::*;
#(
  parameter int VEC_W      = 8,
  parameter int FRAME_QW   = 5,
  parameter int ALIGN_LOG2 = 4,
  parameter int CANON_BIT  = 47
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [VEC_W-1:0] vector,
  input  logic [63:0]      cur_rip,
  input  logic [63:0]      cur_rsp,
  input  logic [63:0]      cur_rflags,
  input  logic [15:0]      cur_cs,
  input  logic [15:0]      cur_ss,
  input  logic [1:0]       cur_cpl,
  input  logic [63:0]      idt_base,
  input  logic [63:0]      gdt_base,
  input  logic [63:0]      ldt_base,
  input  logic             gate_chk_ok,
  input  logic             cs_chk_ok,
  output logic             mem_req_valid,
  output logic             mem_req_write,
  output logic [63:0]      mem_req_addr,
  output logic [63:0]      mem_req_wdata,
  input  logic             mem_req_ready,
  input  logic             mem_rsp_valid,
  input  logic [63:0]      mem_rsp_data,
  output logic             busy,
  output logic             done,
  output logic             fault,
  output logic [15:0]      fault_code,
  output logic             unsup,
  output logic [15:0]      new_cs,
  output logic [63:0]      new_rip,
  output logic [63:0]      new_rsp,
  output logic [63:0]      new_rflags
);
  localparam int SLOT_W = $clog2(FRAME_QW);
  localparam logic [63:0] FLAG_CLR = (64'd1 << 8) | (64'd1 << 9) |
                                     (64'd1 << 14) | (64'd1 << 16);

  seq_state_t        state;
  logic [VEC_W-1:0]  vec_q;
  logic [63:0]       rip_q, rsp_q, rfl_q;
  logic [15:0]       cs_q, ss_q;
  logic [1:0]        cpl_q, dpl_q;
  logic [31:0]       off_hi_q;
  logic [15:0]       off_mid_q, off_low_q, sel_q;
  logic [3:0]        type_q;
  logic [2:0]        ist_q;
  logic [SLOT_W-1:0] slot_q, slot_sel;
  gate_info_t        gi;
  logic [63:0]       base_sp, fg_addr, fg_data;
  logic              rsvd_unused;

  assign rsvd_unused = ^{mem_rsp_data[47], mem_rsp_data[44], mem_rsp_data[39:35]};

  function automatic logic [63:0] gate_addr(input logic [63:0] base,
                                            input logic [VEC_W-1:0] v);
    return base + {{(60-VEC_W){1'b0}}, v, 4'b0000};
  endfunction

  ige_gate_decode #(.CANON_BIT(CANON_BIT)) dec_i (
    .off_mid(off_mid_q), .off_low(off_low_q), .off_high(off_hi_q),
    .gtype(type_q), .ist(ist_q), .sel(sel_q), .info(gi)
  );

  assign slot_sel = (state == S_PUSH) ? slot_q + SLOT_W'(1) : '0;

  ige_frame_gen #(.FRAME_QW(FRAME_QW), .ALIGN_LOG2(ALIGN_LOG2)) fg_i (
    .slot(slot_sel), .ret_rip(rip_q), .old_rsp(rsp_q), .old_rflags(rfl_q),
    .old_cs(cs_q), .old_ss(ss_q), .base_sp(base_sp),
    .slot_addr(fg_addr), .slot_data(fg_data)
  );

  wire hs = mem_req_valid && mem_req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      vec_q <= '0; rip_q <= '0; rsp_q <= '0; rfl_q <= '0;
      cs_q <= '0; ss_q <= '0; cpl_q <= '0; dpl_q <= '0;
      off_hi_q <= '0; off_mid_q <= '0; off_low_q <= '0; sel_q <= '0;
      type_q <= '0; ist_q <= '0; slot_q <= '0;
      mem_req_valid <= 1'b0; mem_req_write <= 1'b0;
      mem_req_addr <= '0; mem_req_wdata <= '0;
      busy <= 1'b0; done <= 1'b0; fault <= 1'b0; unsup <= 1'b0;
      fault_code <= '0;
      new_cs <= '0; new_rip <= '0; new_rsp <= '0; new_rflags <= '0;
    end else begin
      done  <= 1'b0;
      fault <= 1'b0;
      unsup <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          vec_q <= vector; rip_q <= cur_rip; rsp_q <= cur_rsp;
          rfl_q <= cur_rflags; cs_q <= cur_cs; ss_q <= cur_ss; cpl_q <= cur_cpl;
          busy <= 1'b1;
          mem_req_valid <= 1'b1;
          mem_req_write <= 1'b0;
          mem_req_addr  <= gate_addr(idt_base, vector) + 64'd8;
          state <= S_GHI_REQ;
        end
        S_GHI_REQ: if (hs) begin
          mem_req_valid <= 1'b0;
          state <= S_GHI_WAIT;
        end
        S_GHI_WAIT: if (mem_rsp_valid) begin
          off_hi_q      <= mem_rsp_data[31:0];
          mem_req_valid <= 1'b1;
          mem_req_addr  <= gate_addr(idt_base, vec_q);
          state <= S_GLO_REQ;
        end
        S_GLO_REQ: if (hs) begin
          mem_req_valid <= 1'b0;
          state <= S_GLO_WAIT;
        end
        S_GLO_WAIT: if (mem_rsp_valid) begin
          off_mid_q <= mem_rsp_data[63:48];
          type_q    <= mem_rsp_data[43:40];
          ist_q     <= mem_rsp_data[34:32];
          sel_q     <= mem_rsp_data[31:16];
          off_low_q <= mem_rsp_data[15:0];
          state <= S_GATE_CHK;
        end
        S_GATE_CHK: begin
          if (!gate_chk_ok || !gi.type_ok) begin
            fault <= 1'b1; fault_code <= '0; busy <= 1'b0;
            state <= S_IDLE;
          end else begin
            mem_req_valid <= 1'b1;
            mem_req_addr  <= (gi.use_local ? ldt_base : gdt_base) +
                             {56'd0, gi.tbl_off};
            state <= S_CSD_REQ;
          end
        end
        S_CSD_REQ: if (hs) begin
          mem_req_valid <= 1'b0;
          state <= S_CSD_WAIT;
        end
        S_CSD_WAIT: if (mem_rsp_valid) begin
          dpl_q <= mem_rsp_data[46:45];
          state <= S_CS_CHK;
        end
        S_CS_CHK: begin
          if (!cs_chk_ok || !gi.canon) begin
            fault <= 1'b1; fault_code <= '0; busy <= 1'b0;
            state <= S_IDLE;
          end else if ((gi.ist != 3'd0) || (dpl_q != cpl_q)) begin
            unsup <= 1'b1; busy <= 1'b0;
            state <= S_IDLE;
          end else begin
            slot_q        <= '0;
            mem_req_valid <= 1'b1;
            mem_req_write <= 1'b1;
            mem_req_addr  <= fg_addr;
            mem_req_wdata <= fg_data;
            state <= S_PUSH;
          end
        end
        S_PUSH: if (hs) begin
          if (slot_q == SLOT_W'(FRAME_QW - 1)) begin
            mem_req_valid <= 1'b0;
            mem_req_write <= 1'b0;
            state <= S_COMMIT;
          end else begin
            slot_q        <= slot_q + SLOT_W'(1);
            mem_req_addr  <= fg_addr;
            mem_req_wdata <= fg_data;
          end
        end
        S_COMMIT: begin
          new_rsp    <= base_sp;
          new_cs     <= gi.sel;
          new_rip    <= gi.target;
          new_rflags <= (rfl_q & ~FLAG_CLR) | {54'd0, gi.if_bit, 9'd0};
          done <= 1'b1;
          busy <= 1'b0;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ige_entry_seq_chk.sv
module ige_entry_seq_chk (
  input logic        clk,
  input logic        rst,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic        fault,
  input logic        unsup,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic        mem_req_write,
  input logic [63:0] mem_req_addr,
  input logic [63:0] new_rip,
  input logic [63:0] new_rsp,
  input logic [15:0] new_cs,
  input logic [63:0] new_rflags
);
  logic [2:0] wr_cnt;

  always_ff @(posedge clk) begin
    if (rst) wr_cnt <= '0;
    else if (start && !busy) wr_cnt <= '0;
    else if (mem_req_valid && mem_req_ready && mem_req_write) wr_cnt <= wr_cnt + 3'd1;
  end

  p_req_hold_r1: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)));

  p_align_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> (new_rsp[3:0] == 4'h0));

  p_five_writes_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> (wr_cnt == 3'd5));

  p_no_write_r11: assert property (@(posedge clk) disable iff (rst)
    (fault || unsup) |-> (wr_cnt == 3'd0));

  p_keep_regs_r11: assert property (@(posedge clk) disable iff (rst)
    (fault || unsup) |-> ($stable(new_rip) && $stable(new_rsp) &&
                          $stable(new_cs) && $stable(new_rflags)));

  p_one_end_r12: assert property (@(posedge clk) disable iff (rst)
    $onehot0({done, fault, unsup}));

  p_busy_end_r12: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (done || fault || unsup));
endmodule

bind ige_entry_seq ige_entry_seq_chk chk_i (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .fault(fault), .unsup(unsup), .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
  .mem_req_addr(mem_req_addr), .new_rip(new_rip), .new_rsp(new_rsp),
  .new_cs(new_cs), .new_rflags(new_rflags)
);

// File: tb/ige_entry_seq_tb.sv
module ige_entry_seq_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic        start = 1'b0;
  logic [7:0]  vector = '0;
  logic [63:0] cur_rip = '0, cur_rsp = '0, cur_rflags = '0;
  logic [15:0] cur_cs = '0, cur_ss = '0;
  logic [1:0]  cur_cpl = '0;
  logic [63:0] idt_base = 64'h0000_0000_0010_0000;
  logic [63:0] gdt_base = 64'h0000_0000_0020_0000;
  logic [63:0] ldt_base = 64'h0000_0000_0030_0000;
  logic        gate_chk_ok = 1'b1, cs_chk_ok = 1'b1;
  logic        mem_req_valid, mem_req_write, mem_req_ready;
  logic [63:0] mem_req_addr, mem_req_wdata;
  logic        mem_rsp_valid;
  logic [63:0] mem_rsp_data;
  logic        busy, done, fault, unsup;
  logic [15:0] fault_code, new_cs;
  logic [63:0] new_rip, new_rsp, new_rflags;

  ige_entry_seq dut_i (.*);

  int tests = 0, fails = 0;

  // memory model
  logic [63:0] m_hi_addr, m_lo_addr, m_cs_addr, m_hi, m_lo, m_cs;
  logic [63:0] rd_log [0:1023];
  logic [63:0] wa_log [0:1023];
  logic [63:0] wd_log [0:1023];
  int rd_cnt = 0, wr_cnt = 0, tick = 0;

  initial begin
    mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
  end

  always @(posedge clk) begin
    tick <= tick + 1;
    mem_req_ready <= ((tick % 3) != 1);
    mem_rsp_valid <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      if (mem_req_write) begin
        wa_log[wr_cnt[9:0]] <= mem_req_addr;
        wd_log[wr_cnt[9:0]] <= mem_req_wdata;
        wr_cnt <= wr_cnt + 1;
      end else begin
        rd_log[rd_cnt[9:0]] <= mem_req_addr;
        rd_cnt <= rd_cnt + 1;
        mem_rsp_valid <= 1'b1;
        mem_rsp_data <= (mem_req_addr == m_hi_addr) ? m_hi :
                        (mem_req_addr == m_lo_addr) ? m_lo :
                        (mem_req_addr == m_cs_addr) ? m_cs : 64'hDEAD_BEEF_DEAD_BEEF;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input [63:0] act, input [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // outcome: 0 done, 1 fault, 2 unsupported
  task automatic run_case(input [7:0] vec, input [3:0] gtype, input [2:0] ist,
                          input [15:0] sel, input [63:0] off, input [1:0] dpl,
                          input [1:0] cpl, input bit gok, input bit cok,
                          input [63:0] rsp, input [63:0] rfl, input string req);
    logic [63:0] lo, hi, csd, sp, exp_rfl;
    logic [63:0] p_rip, p_rsp, p_rfl;
    logic [15:0] p_cs;
    bit canon;
    int outc, nrd, rd0, wr0, cyc;
    lo = {off[31:16], 4'h8, gtype, 5'b0, ist, sel, off[15:0]};
    hi = {32'h0, off[63:32]};
    csd = 64'h0020_9A00_0000_0000;
    csd[46:45] = dpl;
    m_hi_addr = idt_base + {52'd0, vec, 4'b0} + 64'd8;
    m_lo_addr = idt_base + {52'd0, vec, 4'b0};
    m_cs_addr = (sel[2] ? ldt_base : gdt_base) + {48'd0, sel & 16'h00F8};
    m_hi = hi; m_lo = lo; m_cs = csd;
    canon = (off[63:47] == 17'h0) || (off[63:47] == 17'h1FFFF);
    if (!gok || (gtype & 4'hE) != 4'hE) begin outc = 1; nrd = 2; end
    else if (!cok || !canon) begin outc = 1; nrd = 3; end
    else if (ist != 3'd0 || dpl != cpl) begin outc = 2; nrd = 3; end
    else begin outc = 0; nrd = 3; end
    sp = (rsp - 64'd40) & ~64'hF;
    exp_rfl = (rfl & ~64'h14300) | ({63'd0, gtype[0]} << 9);
    p_rip = new_rip; p_rsp = new_rsp; p_rfl = new_rflags; p_cs = new_cs;
    rd0 = rd_cnt; wr0 = wr_cnt;
    @(negedge clk);
    vector = vec; cur_rip = 64'hFFFF_FFFF_8123_4560 + {56'd0, vec};
    cur_rsp = rsp; cur_rflags = rfl; cur_cs = 16'h0008 | {14'd0, cpl};
    cur_ss = 16'h0010 | {14'd0, cpl}; cur_cpl = cpl;
    gate_chk_ok = gok; cs_chk_ok = cok;
    start = 1'b1;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
      if (cyc == 3) start = 1'b0;
    end while (!(done || fault || unsup));
    start = 1'b0;
    chk((outc == 0) ? done : (outc == 1) ? fault : unsup, req, {61'd0, unsup, fault, done}, 64'(outc));
    chk(!busy, "R12 busy low at end", {63'd0, busy}, 64'd0);
    chk(rd_cnt - rd0 == nrd, "R12 start ignored while busy / read count", 64'(rd_cnt - rd0), 64'(nrd));
    chk(rd_log[rd0[9:0]] == m_hi_addr, "R1 upper gate read first", rd_log[rd0[9:0]], m_hi_addr);
    chk(rd_log[(rd0 + 1) % 1024] == m_lo_addr, "R1 lower gate read second", rd_log[(rd0 + 1) % 1024], m_lo_addr);
    if (nrd == 3)
      chk(rd_log[(rd0 + 2) % 1024] == m_cs_addr, "R3 descriptor table address", rd_log[(rd0 + 2) % 1024], m_cs_addr);
    if (outc == 1) chk(fault_code == 16'h0, "R2 fault code zero", {48'd0, fault_code}, 64'd0);
    if (outc == 0) begin
      chk(wr_cnt - wr0 == 5, "R8 five frame writes", 64'(wr_cnt - wr0), 64'd5);
      for (int k = 0; k < 5; k++) begin
        logic [63:0] ed;
        case (k)
          0: ed = cur_rip;
          1: ed = {48'd0, cur_cs};
          2: ed = rfl;
          3: ed = rsp;
          default: ed = {48'd0, cur_ss};
        endcase
        chk(wa_log[(wr0 + k) % 1024] == sp + 64'(8 * k), "R8 frame slot address",
            wa_log[(wr0 + k) % 1024], sp + 64'(8 * k));
        chk(wd_log[(wr0 + k) % 1024] == ed, "R8 frame slot data", wd_log[(wr0 + k) % 1024], ed);
      end
      chk(new_rsp == sp, "R7 aligned new stack pointer", new_rsp, sp);
      chk(new_cs == sel, "R9 new code selector", {48'd0, new_cs}, {48'd0, sel});
      chk(new_rip == off, "R9 new instruction pointer", new_rip, off);
      chk(new_rflags == exp_rfl, "R10 new flags", new_rflags, exp_rfl);
    end else begin
      chk(wr_cnt == wr0, "R11 no write on fault/unsupported", 64'(wr_cnt - wr0), 64'd0);
      chk(new_rip == p_rip && new_rsp == p_rsp && new_rflags == p_rfl && new_cs == p_cs,
          "R11 outputs unchanged", new_rip, p_rip);
    end
    @(negedge clk);
    chk(!(done || fault || unsup), "R12 end pulse lasts one cycle", {61'd0, unsup, fault, done}, 64'd0);
  endtask

  localparam logic [63:0] OFF_OK = 64'hFFFF_FFFF_8000_1234;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !fault && !unsup && !mem_req_valid, "R12 reset idle",
        {59'd0, mem_req_valid, busy, done, fault, unsup}, 64'd0);
    chk(new_rip == 0 && new_rsp == 0 && new_rflags == 0 && new_cs == 0,
        "R9 reset outputs zero", new_rip, 64'd0);
    // R2 / R10: all gate types
    for (int t = 0; t < 16; t++)
      run_case(8'(t * 7 + 3), 4'(t), 3'd0, 16'h0010, OFF_OK, 2'd0, 2'd0, 1'b1, 1'b1,
               64'h0000_7000_1008 + 64'(t * 24), 64'h0000_0000_0005_43D7 ^ 64'(t << 12),
               "R2 gate type sweep");
    // R6: stack-table index sweep
    for (int i = 1; i < 8; i++)
      run_case(8'(40 + i), 4'hE, 3'(i), 16'h0010, OFF_OK, 2'd0, 2'd0, 1'b1, 1'b1,
               64'h8000, 64'h202, "R6 stack index unsupported");
    // R6: privilege sweep at current level 3
    for (int d = 0; d < 4; d++)
      run_case(8'(60 + d), 4'hF, 3'd0, 16'h0023, OFF_OK, 2'(d), 2'd3, 1'b1, 1'b1,
               64'h0000_7FFF_FFF0_0000, 64'h0001_4302, "R6 privilege compare");
    // R4: canonical boundaries
    run_case(8'd80, 4'hE, 3'd0, 16'h0010, 64'h0000_7FFF_FFFF_FFF0, 2'd0, 2'd0, 1'b1, 1'b1, 64'h9000, 64'h2, "R4 canonical low top");
    run_case(8'd81, 4'hE, 3'd0, 16'h0010, 64'h0000_8000_0000_0000, 2'd0, 2'd0, 1'b1, 1'b1, 64'h9000, 64'h2, "R4 non-canonical");
    run_case(8'd82, 4'hE, 3'd0, 16'h0010, 64'hFFFF_8000_0000_0000, 2'd0, 2'd0, 1'b1, 1'b1, 64'h9000, 64'h2, "R4 canonical high bottom");
    run_case(8'd83, 4'hE, 3'd0, 16'h0010, 64'hFFFF_7FFF_FFFF_FFFF, 2'd0, 2'd0, 1'b1, 1'b1, 64'h9000, 64'h2, "R4 non-canonical high");
    // R3: table selection
    run_case(8'd90, 4'hF, 3'd0, 16'h0014, OFF_OK, 2'd0, 2'd0, 1'b1, 1'b1, 64'hA000, 64'h302, "R3 local table");
    run_case(8'd91, 4'hF, 3'd0, 16'h0028, OFF_OK, 2'd0, 2'd0, 1'b1, 1'b1, 64'hA000, 64'h302, "R3 global table");
    run_case(8'd92, 4'hE, 3'd0, 16'h00FF, OFF_OK, 2'd0, 2'd0, 1'b1, 1'b1, 64'hA000, 64'h302, "R3 local table rpl bits");
    // R5: permission inputs
    run_case(8'd100, 4'hE, 3'd0, 16'h0010, OFF_OK, 2'd0, 2'd0, 1'b0, 1'b1, 64'hB000, 64'h2, "R5 gate permission");
    run_case(8'd101, 4'hE, 3'd0, 16'h0010, OFF_OK, 2'd0, 2'd0, 1'b1, 1'b0, 64'hB000, 64'h2, "R5 code-segment permission");
    // R11: fault and unsupported condition in the same cycle
    run_case(8'd110, 4'hE, 3'd5, 16'h0010, 64'h0001_0000_0000_0000, 2'd0, 2'd0, 1'b1, 1'b1, 64'hC000, 64'h2, "R11 fault wins over stack index");
    run_case(8'd111, 4'hE, 3'd0, 16'h0010, OFF_OK, 2'd2, 2'd0, 1'b1, 1'b0, 64'hC000, 64'h2, "R11 fault wins over privilege change");
    // R7: stack pointer low nibble sweep
    for (int k = 0; k < 16; k++)
      run_case(8'(200 + k), 4'hE, 3'd0, 16'h0010, OFF_OK, 2'd0, 2'd0, 1'b1, 1'b1,
               64'h0000_0000_0012_3450 + 64'(k), 64'h0000_0000_0001_FFFF, "R7 stack alignment sweep");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule